// File: doc/BRIEF.md
# Two-Level Adaptive Branch Predictor

This block sits in the fetch stage and predicts, for each fetch address, whether the fetch is a taken branch and where fetch should go next. The first level is a set-associative table of per-address local histories, tagged by the fetch line address. Each entry holds the last four outcomes of one branch. The second level is a bank of small pattern tables of 2-bit saturating counters. The low line-address bits choose one table and the local history chooses the counter inside it. A direct-mapped, tagged target buffer supplies the destination. A taken prediction is issued only when the history table hits, the selected counter's upper bit is set and the target buffer also hits. In every other case the prediction is not-taken and the next target is the sequential line.

The branch unit returns a resolved outcome, target and misprediction flag on the update port. The block then trains the counter selected by the history as it stood before the update. It shifts the outcome into the history and records the target of a taken branch. A resolved taken branch that misses the history table is given an entry chosen by tree pseudo-LRU. A misprediction also produces a one-cycle redirect carrying the corrected fetch address.

Top module: `bpred_top`

## Requirements
- R1: After reset, pr_valid, pr_taken and redir_valid are 0, every history entry is invalid and every counter holds 01 (weakly not-taken).
- R2: A lookup with lk_valid high in cycle N gives pr_valid high with its prediction after the clock edge that ends cycle N. pr_valid is 0 after a cycle without lk_valid.
- R3: A lookup whose line address misses the history table predicts not-taken with pr_target = lk_pc + 16. A line is 16 bytes, so pc[3:0] is the in-line offset.
- R4: A taken update that misses the history table allocates an entry whose history is 0000. It increments counter 0 of the table chosen by pc[10:4]. A not-taken update that misses changes nothing.
- R5: On a hit, the counter is selected by table pc[10:4] and the 4-bit history, and its bit 1 is the direction. An update trains that same counter and then shifts the history left, with the new outcome entering bit 0.
- R6: Counters saturate at 00 and 11. A counter at 11 still predicts taken after one not-taken outcome.
- R7: The target buffer has 64 entries indexed by pc[9:4] and is tagged with pc[31:10]. It is written by every taken update. A taken direction whose target buffer entry holds another branch's tag yields not-taken with the sequential target.
- R8: The history table has 128 sets of 4 ways. Allocation takes the tree pseudo-LRU victim. From reset, a set fills ways 0, 2, 1 and 3 in that order, and a fifth allocation evicts the first entry.
- R9: An update with up_mispredict high gives redir_valid high one cycle later. redir_pc is up_target for a taken outcome and up_pc + 16 for a not-taken outcome. Otherwise redir_valid is 0.
- R10: When a lookup and an update address the same entry in one cycle, the lookup is answered from the state held before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch address to predict |
| pr_valid | output | 1 | Prediction valid, one cycle after lookup |
| pr_taken | output | 1 | Predicted taken |
| pr_target | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | Resolved branch update |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | PC_W | Resolved taken target |
| up_mispredict | input | 1 | The earlier prediction was wrong |
| redir_valid | output | 1 | Fetch redirect valid |
| redir_pc | output | PC_W | Corrected fetch address |

## Verification
Taken-only runs on one branch walk its history from 0000 to 1111. This shows that each new history reaches a fresh counter and separates history indexing from per-table indexing. Taken and not-taken runs at a fixed history push one counter to both rails and show saturation and hysteresis. Two branches that share a target buffer slot but not a history set separate a direction hit from a target hit. Five branches that share one history set confirm the pseudo-LRU fill order and eviction: a re-allocated entry restarts at history 0000, while a surviving entry shifts its history. A lookup and an update on the same entry in one cycle show that the lookup is answered from the old state.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   typedef logic [1:0] ctr_t;

   // weakly not-taken
   localparam ctr_t CTR_INIT = 2'b01;

   function automatic ctr_t ctr_step(input ctr_t c, input logic up);
      ctr_t r;
      if (up) r = (c == 2'b11) ? c : c + 2'd1;
      else    r = (c == 2'b00) ? c : c - 2'd1;
      return r;
   endfunction

endpackage

// File: rtl/bpred_hist.sv
// First level: set-associative local history table with tree pseudo-LRU.
module bpred_hist #(
   parameter int LA_W   = 28,
   parameter int SETS   = 128,
   parameter int WAYS   = 4,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   lk_la,
   output logic              lk_hit,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic [LA_W-1:0]   up_la,
   input  logic              up_taken,
   output logic              up_hit,
   output logic [HIST_W-1:0] up_hist
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = LA_W - SET_W;

   logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
   logic              vld_q  [SETS][WAYS];
   logic [HIST_W-1:0] hist_q [SETS][WAYS];
   logic [WAYS-2:0]   plru_q [SETS];

   logic [SET_W-1:0] lk_set, up_set;
   logic [TAG_W-1:0] lk_tag, up_tag;
   logic [WAY_W-1:0] up_way, victim, touch_way;
   logic [WAYS-2:0]  plru_cur, plru_nxt;

   assign lk_set = lk_la[SET_W-1:0];
   assign lk_tag = lk_la[LA_W-1:SET_W];
   assign up_set = up_la[SET_W-1:0];
   assign up_tag = up_la[LA_W-1:SET_W];

   always_comb begin
      lk_hit  = 1'b0;
      lk_hist = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
            lk_hit  = 1'b1;
            lk_hist = hist_q[lk_set][w];
         end
      end
   end

   always_comb begin
      up_hit  = 1'b0;
      up_hist = '0;
      up_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[up_set][w] && tag_q[up_set][w] == up_tag) begin
            up_hit  = 1'b1;
            up_hist = hist_q[up_set][w];
            up_way  = w[WAY_W-1:0];
         end
      end
   end

   assign plru_cur  = plru_q[up_set];
   assign touch_way = up_hit ? up_way : victim;

   generate
      if (WAYS == 2) begin : g_plru2
         assign victim   = plru_cur[0];
         assign plru_nxt = ~touch_way;
      end else begin : g_plru4
         // bit0 picks the half, bit1 the lower pair, bit2 the upper pair
         assign victim = plru_cur[0] ? {1'b1, plru_cur[2]} : {1'b0, plru_cur[1]};
         always_comb begin
            plru_nxt    = plru_cur;
            plru_nxt[0] = ~touch_way[1];
            if (touch_way[1]) plru_nxt[2] = ~touch_way[0];
            else              plru_nxt[1] = ~touch_way[0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            plru_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               vld_q[s][w]  <= 1'b0;
               tag_q[s][w]  <= '0;
               hist_q[s][w] <= '0;
            end
         end
      end else if (up_valid) begin
         if (up_hit) begin
            hist_q[up_set][up_way] <= {up_hist[HIST_W-2:0], up_taken};
            plru_q[up_set]         <= plru_nxt;
         end else if (up_taken) begin
            vld_q[up_set][victim]  <= 1'b1;
            tag_q[up_set][victim]  <= up_tag;
            hist_q[up_set][victim] <= '0;
            plru_q[up_set]         <= plru_nxt;
         end
      end
   end

endmodule

// File: rtl/bpred_pht.sv
// Second level: bank of per-address pattern tables of 2-bit counters.
module bpred_pht
   import bpred_pkg::*;
#(
   parameter int TABLES = 128,
   parameter int HIST_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(TABLES)-1:0]  lk_tbl,
   input  logic [HIST_W-1:0]          lk_hist,
   output ctr_t                       lk_ctr,
   input  logic                       up_en,
   input  logic [$clog2(TABLES)-1:0]  up_tbl,
   input  logic [HIST_W-1:0]          up_hist,
   input  logic                       up_taken
);
   localparam int TBL_W = $clog2(TABLES);
   localparam int IDX_W = TBL_W + HIST_W;
   localparam int DEPTH = TABLES << HIST_W;

   ctr_t ctr_q [DEPTH];

   logic [IDX_W-1:0] lk_idx, up_idx;
   assign lk_idx = {lk_tbl, lk_hist};
   assign up_idx = {up_tbl, up_hist};
   assign lk_ctr = ctr_q[lk_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
      end else if (up_en) begin
         ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
      end
   end

endmodule

// File: rtl/bpred_tgt.sv
// Direct-mapped, tagged target buffer.
module bpred_tgt #(
   parameter int LA_W    = 28,
   parameter int PC_W    = 32,
   parameter int ENTRIES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LA_W-1:0]  lk_la,
   output logic             lk_hit,
   output logic [PC_W-1:0]  lk_tgt,
   input  logic             up_en,
   input  logic [LA_W-1:0]  up_la,
   input  logic [PC_W-1:0]  up_tgt
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = LA_W - IDX_W;

   logic             vld_q [ENTRIES];
   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic [PC_W-1:0]  tgt_q [ENTRIES];

   logic [IDX_W-1:0] lk_idx, up_idx;
   assign lk_idx = lk_la[IDX_W-1:0];
   assign up_idx = up_la[IDX_W-1:0];

   assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_la[LA_W-1:IDX_W]);
   assign lk_tgt = tgt_q[lk_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            tgt_q[i] <= '0;
         end
      end else if (up_en) begin
         vld_q[up_idx] <= 1'b1;
         tag_q[up_idx] <= up_la[LA_W-1:IDX_W];
         tgt_q[up_idx] <= up_tgt;
      end
   end

endmodule

// File: rtl/bpred_top.sv
module bpred_top
   import bpred_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int OFF_W       = 4,
   parameter int BHT_SETS    = 128,
   parameter int BHT_WAYS    = 4,
   parameter int HIST_W      = 4,
   parameter int PHT_TABLES  = 128,
   parameter int BTB_ENTRIES = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   output logic            pr_valid,
   output logic            pr_taken,
   output logic [PC_W-1:0] pr_target,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_target,
   input  logic            up_mispredict,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_pc
);
   localparam int LA_W  = PC_W - OFF_W;
   localparam int TBL_W = $clog2(PHT_TABLES);
   localparam logic [PC_W-1:0] STEP = {{(PC_W-1){1'b0}}, 1'b1} << OFF_W;

   initial begin : prm_chk
      assert (BHT_WAYS == 2 || BHT_WAYS == 4)
         else $fatal(1, "BHT_WAYS must be 2 or 4");
      assert ((1 << $clog2(BHT_SETS)) == BHT_SETS)
         else $fatal(1, "BHT_SETS must be a power of two");
      assert ((1 << TBL_W) == PHT_TABLES && TBL_W <= LA_W)
         else $fatal(1, "PHT_TABLES must be a power of two within the line address");
      assert ((1 << $clog2(BTB_ENTRIES)) == BTB_ENTRIES && $clog2(BTB_ENTRIES) < LA_W)
         else $fatal(1, "BTB_ENTRIES must be a power of two below the line address range");
      assert (HIST_W >= 2)
         else $fatal(1, "HIST_W must be at least 2");
   end

   logic [LA_W-1:0] lk_la, up_la;
   assign lk_la = lk_pc[PC_W-1:OFF_W];
   assign up_la = up_pc[PC_W-1:OFF_W];

   logic              h_lk_hit, h_up_hit;
   logic [HIST_W-1:0] h_lk_hist, h_up_hist;
   ctr_t              lk_ctr;
   logic              t_lk_hit;
   logic [PC_W-1:0]   t_lk_tgt;

   bpred_hist #(
      .LA_W(LA_W), .SETS(BHT_SETS), .WAYS(BHT_WAYS), .HIST_W(HIST_W)
   ) u_hist (
      .clk(clk), .rst_n(rst_n),
      .lk_la(lk_la), .lk_hit(h_lk_hit), .lk_hist(h_lk_hist),
      .up_valid(up_valid), .up_la(up_la), .up_taken(up_taken),
      .up_hit(h_up_hit), .up_hist(h_up_hist)
   );

   // a miss-allocation starts at history zero, so it trains counter zero
   logic              p_up_en;
   logic [HIST_W-1:0] p_up_hist;
   assign p_up_en   = up_valid && (h_up_hit || up_taken);
   assign p_up_hist = h_up_hit ? h_up_hist : '0;

   bpred_pht #(
      .TABLES(PHT_TABLES), .HIST_W(HIST_W)
   ) u_pht (
      .clk(clk), .rst_n(rst_n),
      .lk_tbl(lk_la[TBL_W-1:0]), .lk_hist(h_lk_hist), .lk_ctr(lk_ctr),
      .up_en(p_up_en), .up_tbl(up_la[TBL_W-1:0]), .up_hist(p_up_hist),
      .up_taken(up_taken)
   );

   bpred_tgt #(
      .LA_W(LA_W), .PC_W(PC_W), .ENTRIES(BTB_ENTRIES)
   ) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .lk_la(lk_la), .lk_hit(t_lk_hit), .lk_tgt(t_lk_tgt),
      .up_en(up_valid && up_taken), .up_la(up_la), .up_tgt(up_target)
   );

   logic lk_take;
   assign lk_take = h_lk_hit && lk_ctr[1] && t_lk_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_valid    <= 1'b0;
         pr_taken    <= 1'b0;
         pr_target   <= '0;
         redir_valid <= 1'b0;
         redir_pc    <= '0;
      end else begin
         pr_valid    <= lk_valid;
         pr_taken    <= lk_valid && lk_take;
         pr_target   <= lk_take ? t_lk_tgt : lk_pc + STEP;
         redir_valid <= up_valid && up_mispredict;
         redir_pc    <= up_taken ? up_target : up_pc + STEP;
      end
   end

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [PC_W-1:0] lk_pc,
   input logic            pr_valid,
   input logic            pr_taken,
   input logic [PC_W-1:0] pr_target,
   input logic            up_valid,
   input logic [PC_W-1:0] up_pc,
   input logic            up_taken,
   input logic [PC_W-1:0] up_target,
   input logic            up_mispredict,
   input logic            redir_valid,
   input logic [PC_W-1:0] redir_pc
);
   localparam logic [PC_W-1:0] STEP = {{(PC_W-1){1'b0}}, 1'b1} << OFF_W;

   // R2
   lookup_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pr_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pr_valid && !pr_taken);

   // R3
   fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (pr_taken || pr_target == $past(lk_pc) + STEP));

   // R9
   redir_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && up_mispredict && up_taken |=> redir_valid && redir_pc == $past(up_target));

   // R9
   redir_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && up_mispredict && !up_taken |=> redir_valid && redir_pc == $past(up_pc) + STEP);

   // R9
   no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_valid && up_mispredict) |=> !redir_valid);

endmodule

bind bpred_top bpred_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
   .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_target(pr_target),
   .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
   .up_target(up_target), .up_mispredict(up_mispredict),
   .redir_valid(redir_valid), .redir_pc(redir_pc)
);

// File: tb/sim_bpred_top.sv
module sim_bpred_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        pr_valid, pr_taken;
   logic [31:0] pr_target;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [31:0] up_target = '0;
   logic        up_mispredict = 1'b0;
   logic        redir_valid;
   logic [31:0] redir_pc;

   always #2 clk = ~clk;   // 250 MHz

   bpred_top u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc),
      .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_target(pr_target),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_target(up_target), .up_mispredict(up_mispredict),
      .redir_valid(redir_valid), .redir_pc(redir_pc)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct packed {
      logic        lk;
      logic        up;
      logic [31:0] pc;
      logic        tk;
      logic [31:0] tgt;
      logic        mp;
      logic        e_tk;
      logic [31:0] e_tgt;
      logic        e_rv;
      logic [31:0] e_rpc;
      logic [3:0]  req;
   } vec_t;

   localparam logic        Y  = 1'b1;
   localparam logic        N  = 1'b0;
   localparam logic [31:0] Z  = 32'h0;
   localparam logic [31:0] A  = 32'h0000_1230;
   localparam logic [31:0] FA = 32'h0000_1240;
   localparam logic [31:0] TA = 32'h0000_8000;
   localparam logic [31:0] D  = 32'h0000_2050;
   localparam logic [31:0] FD = 32'h0000_2060;
   localparam logic [31:0] TD = 32'h0000_A000;
   localparam logic [31:0] E  = 32'h0000_2450;
   localparam logic [31:0] TE = 32'h0000_B000;

   localparam int NV = 34;
   // lk up pc tk tgt mp | exp taken, exp target, exp redirect, exp redirect pc, requirement
   localparam vec_t VEC [NV] = '{
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd3},   // R3 miss -> not-taken
      '{N, Y, A, Y, TA, Y, N, Z,  Y, TA, 4'd4},   // R4 allocate, R9 redirect to target
      '{Y, N, A, N, Z,  N, Y, TA, N, Z,  4'd4},   // R4 hist 0000, counter 10
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd5},   // R5 hist -> 0001
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd5},   // R5 counter 1 untouched
      '{N, Y, A, Y, TA, Y, N, Z,  Y, TA, 4'd9},   // R9 hist -> 0011
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd5},   // hist -> 0111
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd5},   // hist -> 1111
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd5},   // R5 counter 15 still 01
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd6},   // c15 10
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd6},   // c15 11
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd6},   // c15 stays 11
      '{Y, N, A, N, Z,  N, Y, TA, N, Z,  4'd6},   // R6 top saturation
      '{N, Y, A, N, Z,  Y, N, Z,  Y, FA, 4'd9},   // R9 not-taken redirect, hist 1110
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd5},   // c14 01
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd5},   // hist 1100
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd5},   // hist 1000
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd5},   // hist 0000
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd6},   // c0 11 -> 10
      '{Y, N, A, N, Z,  N, Y, TA, N, Z,  4'd6},   // R6 hysteresis
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd6},   // c0 01
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd6},   // c0 00
      '{N, Y, A, N, Z,  N, N, Z,  N, Z,  4'd6},   // c0 stays 00
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd6},   // R6 bottom saturation
      '{N, Y, A, Y, TA, N, N, Z,  N, Z,  4'd5},   // c0 01, hist 0001
      '{Y, N, A, N, Z,  N, Y, TA, N, Z,  4'd5},   // R5 c1 10 from earlier
      '{Y, Y, A, N, Z,  N, Y, TA, N, Z,  4'd10},  // R10 lookup sees old state
      '{Y, N, A, N, Z,  N, N, FA, N, Z,  4'd10},  // R10 update landed: hist 0010
      '{N, Y, D, Y, TD, N, N, Z,  N, Z,  4'd4},   // allocate D
      '{Y, N, D, N, Z,  N, Y, TD, N, Z,  4'd7},   // R7 target hit
      '{N, Y, E, Y, TE, N, N, Z,  N, Z,  4'd7},   // E overwrites target slot
      '{Y, N, D, N, Z,  N, N, FD, N, Z,  4'd7},   // R7 target miss -> not-taken
      '{Y, N, E, N, Z,  N, Y, TE, N, Z,  4'd7},   // R7 E taken
      '{N, N, Z, N, Z,  N, N, Z,  N, Z,  4'd2}    // R2 idle -> no prediction
   };

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic cyc(input logic lk, input logic up, input logic [31:0] pc,
                      input logic tk, input logic [31:0] tgt, input logic mp);
      @(negedge clk);
      lk_valid = lk; lk_pc = pc;
      up_valid = up; up_pc = pc; up_taken = tk; up_target = tgt; up_mispredict = mp;
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 pr_valid", {31'b0, pr_valid}, 32'd0);
      check("R1 pr_taken", {31'b0, pr_taken}, 32'd0);
      check("R1 redir_valid", {31'b0, redir_valid}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i].lk, VEC[i].up, VEC[i].pc, VEC[i].tk, VEC[i].tgt, VEC[i].mp);
         check($sformatf("R%0d v%0d pr_valid", VEC[i].req, i), {31'b0, pr_valid}, {31'b0, VEC[i].lk});
         if (VEC[i].lk) begin
            check($sformatf("R%0d v%0d pr_taken", VEC[i].req, i), {31'b0, pr_taken}, {31'b0, VEC[i].e_tk});
            check($sformatf("R%0d v%0d pr_target", VEC[i].req, i), pr_target, VEC[i].e_tgt);
         end
         check($sformatf("R%0d v%0d redir_valid", VEC[i].req, i), {31'b0, redir_valid}, {31'b0, VEC[i].e_rv});
         if (VEC[i].e_rv)
            check($sformatf("R%0d v%0d redir_pc", VEC[i].req, i), redir_pc, VEC[i].e_rpc);
      end

      // R8 five branches in set pc[10:4]=0x30; fill order ways 0,2,1,3
      for (int k = 0; k < 5; k++)
         cyc(N, Y, 32'h0001_0300 + 32'(k) * 32'h800, Y, 32'h0004_0000 + 32'(k) * 32'h100, N);
      cyc(Y, N, 32'h0001_2300, N, Z, N);
      check("R8 newest entry predicts taken", {31'b0, pr_taken}, 32'd1);
      check("R8 newest entry target", pr_target, 32'h0004_0400);
      // first branch was evicted: re-allocation restarts at history 0000 (counter 11)
      cyc(N, Y, 32'h0001_0300, Y, 32'h0004_0000, N);
      cyc(Y, N, 32'h0001_0300, N, Z, N);
      check("R8 evicted branch re-allocated", {31'b0, pr_taken}, 32'd1);
      check("R8 evicted branch target", pr_target, 32'h0004_0000);
      // third branch survived: update shifts its history to 0001 (counter 01)
      cyc(N, Y, 32'h0001_1300, Y, 32'h0004_0200, N);
      cyc(Y, N, 32'h0001_1300, N, Z, N);
      check("R8 surviving branch shifted history", {31'b0, pr_taken}, 32'd0);
      check("R8 surviving branch target", pr_target, 32'h0001_1310);

      // R4 not-taken update on a miss allocates nothing: a later taken update
      // must allocate fresh (history 0000, counter 10 -> taken)
      cyc(N, Y, 32'h0003_0700, N, Z, N);
      cyc(N, Y, 32'h0003_0700, Y, 32'h0005_0000, N);
      cyc(Y, N, 32'h0003_0700, N, Z, N);
      check("R4 not-taken miss ignored", {31'b0, pr_taken}, 32'd1);

      // R1 reset clears entries: branch A misses again
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cyc(Y, N, A, N, Z, N);
      check("R1 entries cleared", {31'b0, pr_taken}, 32'd0);
      check("R1 fall-through after reset", pr_target, FA);

      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule